// File: doc/BRIEF.md
# Power Stage Control and Status Registers

This block is a small register-mapped unit that governs the power stages of a driver chip. Software reaches it over a simple synchronous bus made of an address, write data, a write strobe, a read strobe and registered read data. A control register holds a master enable for all power stages and a two-bit LIN slew-rate code. A power output register holds the on bit for a switchable supply output and a three-bit current-limit code. Both codes are passed straight out to the analog circuits that act on them.

A status register reports the digital fault flags of the protection circuits. Most of them are live copies of their inputs. The one exception is the supply overcurrent flag. It latches when the overcurrent input fires, and it keeps the switchable supply output off until software writes a one to it. Once the flag is cleared, the output comes back on, provided the master enable and the output-on bit are still set.

The supply output can also be shut down by the over-temperature flag, but only while the high-temperature reset enable input is set. Low-voltage and high-voltage conditions are reported in the status register and have no effect on the output.

Top module: `pwr_stage_regs`

## Requirements
- R1: After reset, every register bit is 0. The outputs stage_en, slew_sel, ilim_sel and sup_out_en are 0, and reads of 0x03, 0x01 and 0x0C (with all flag inputs low) return 0x00.
- R2: The control register is at 0x03. Bit 7 drives stage_en. Bits 6:5 drive slew_sel unchanged, with codes 00 = 20 kBaud initial, 01 = 10 kBaud slow, 10 = 8x high speed, 11 = 4x high speed. Bits 4:0 ignore writes and read as 0.
- R3: The power output register is at 0x01. Bit 7 is the supply output-on bit. Bits 2:0 drive ilim_sel unchanged: 000 means no limit, and 011 through 111 select rising limits. Bits 6:3 ignore writes and read as 0.
- R4: sup_out_en is 1 only when all of the following hold: stage_en is 1, the output-on bit is 1, the overcurrent flag is clear, sup_oc_in is low, and no over-temperature shutdown is active.
- R5: While sup_oc_in is high, sup_out_en is 0 in the same cycle. The overcurrent flag (status bit 5) is set from the next clock edge onwards and stays set after sup_oc_in falls.
- R6: A write to 0x0C with bit 5 = 1 clears the overcurrent flag, and the output returns. A write with bit 5 = 0 leaves the flag set.
- R7: If sup_oc_in is high in the same cycle as a clearing write, the flag stays set and the output stays off.
- R8: When ht_flag_in and ht_rst_en_in are both 1, sup_out_en is 0. ht_flag_in alone has no effect on the output.
- R9: The status register at 0x0C reads {0, lin_ilim_in, oc flag, 0, lv_flag_in, hv_flag_in, hb_oc_in, ht_flag_in}, from bit 7 down to bit 0. Every bit except bit 5 is read-only, and writes to those bits are ignored. lv_flag_in and hv_flag_in do not affect sup_out_en.
- R10: Read data is registered and is valid in the cycle after the read strobe. It is 0 for unmapped addresses, and 0 in any cycle that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| sup_oc_in | input | 1 | Supply output overcurrent detect |
| lin_ilim_in | input | 1 | LIN transmitter in current limit |
| lv_flag_in | input | 1 | Low-voltage flag |
| hv_flag_in | input | 1 | High-voltage flag |
| hb_oc_in | input | 1 | Half-bridge overcurrent flag |
| ht_flag_in | input | 1 | High-temperature flag |
| ht_rst_en_in | input | 1 | High-temperature reset enable |
| stage_en | output | 1 | Master power-stage enable |
| slew_sel | output | 2 | LIN slew-rate code |
| ilim_sel | output | 3 | Current-limit code |
| sup_out_en | output | 1 | Switchable supply output enable |

## Verification
The assertions check on every cycle the properties that link inputs to outputs. The output is never on without the master enable. An overcurrent or an enabled over-temperature condition forces the output off at once. The flag sets after an overcurrent and is held by any write that does not clear it. Idle cycles return zero read data. The bench scenarios show the register layouts and code pass-through, the live status copies, and that writing zero or writing read-only bits has no effect. They also show the set-over-clear collision and that the output comes back after a clear.

// File: rtl/pwr_stage_regs.sv
module pwr_stage_regs #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] PWR_ADDR  = 8'h01,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h03,
  parameter logic [AW-1:0] STAT_ADDR = 8'h0C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  input  logic          sup_oc_in,
  input  logic          lin_ilim_in,
  input  logic          lv_flag_in,
  input  logic          hv_flag_in,
  input  logic          hb_oc_in,
  input  logic          ht_flag_in,
  input  logic          ht_rst_en_in,
  output logic          stage_en,
  output logic [1:0]    slew_sel,
  output logic [2:0]    ilim_sel,
  output logic          sup_out_en
);

  logic       stage_q;
  logic [1:0] slew_q;
  logic       sup_on_q;
  logic [2:0] ilim_q;
  logic       oc_flag;
  logic [DW-1:0] rd_mux;

  wire wr_ctrl = bus_we && (bus_addr == CTRL_ADDR);
  wire wr_pwr  = bus_we && (bus_addr == PWR_ADDR);
  wire oc_clr  = bus_we && (bus_addr == STAT_ADDR) && bus_wdata[5];
  wire ovt_off = ht_flag_in && ht_rst_en_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q  <= 1'b0;
      slew_q   <= 2'b00;
      sup_on_q <= 1'b0;
      ilim_q   <= 3'b000;
    end else begin
      if (wr_ctrl) begin
        stage_q <= bus_wdata[7];
        slew_q  <= bus_wdata[6:5];
      end
      if (wr_pwr) begin
        sup_on_q <= bus_wdata[7];
        ilim_q   <= bus_wdata[2:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         oc_flag <= 1'b0;
    else if (sup_oc_in) oc_flag <= 1'b1;
    else if (oc_clr)    oc_flag <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == CTRL_ADDR)
      rd_mux = {stage_q, slew_q, 5'b0};
    else if (bus_addr == PWR_ADDR)
      rd_mux = {sup_on_q, 4'b0, ilim_q};
    else if (bus_addr == STAT_ADDR)
      rd_mux = {1'b0, lin_ilim_in, oc_flag, 1'b0,
                lv_flag_in, hv_flag_in, hb_oc_in, ht_flag_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  assign stage_en   = stage_q;
  assign slew_sel   = slew_q;
  assign ilim_sel   = ilim_q;
  assign sup_out_en = stage_q && sup_on_q && !oc_flag && !sup_oc_in && !ovt_off;

endmodule

module pwr_stage_regs_chk #(
  parameter logic [7:0] STAT_ADDR = 8'h0C
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_we,
  input logic       bus_re,
  input logic [7:0] bus_rdata,
  input logic       sup_oc_in,
  input logic       ht_flag_in,
  input logic       ht_rst_en_in,
  input logic       stage_en,
  input logic       sup_out_en,
  input logic       oc_flag
);
  AST_OUT_NEEDS_STAGE: assert property (@(posedge clk) disable iff (!rst_n) sup_out_en |-> stage_en); // R4
  AST_OC_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n) sup_oc_in |-> !sup_out_en); // R5
  AST_OC_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n) sup_oc_in |=> oc_flag); // R5
  AST_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n) oc_flag |-> !sup_out_en); // R5
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_flag && !(bus_we && bus_addr == STAT_ADDR && bus_wdata[5])) |=> oc_flag); // R6
  AST_OVT_OFF: assert property (@(posedge clk) disable iff (!rst_n) (ht_flag_in && ht_rst_en_in) |-> !sup_out_en); // R8
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n) !bus_re |=> bus_rdata == 8'h00); // R10
endmodule

bind pwr_stage_regs pwr_stage_regs_chk #(.STAT_ADDR(STAT_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .sup_oc_in(sup_oc_in), .ht_flag_in(ht_flag_in), .ht_rst_en_in(ht_rst_en_in),
  .stage_en(stage_en), .sup_out_en(sup_out_en), .oc_flag(oc_flag)
);

// File: tb/pwr_stage_regs_tb.sv
module pwr_stage_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic sup_oc_in = 0, lin_ilim_in = 0, lv_flag_in = 0, hv_flag_in = 0;
  logic hb_oc_in = 0, ht_flag_in = 0, ht_rst_en_in = 0;
  logic stage_en, sup_out_en;
  logic [1:0] slew_sel;
  logic [2:0] ilim_sel;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic re_seen = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_stage_regs dut_i (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  function automatic logic [7:0] stat(input logic oc);
    return {1'b0, lin_ilim_in, oc, 1'b0, lv_flag_in, hv_flag_in, hb_oc_in, ht_flag_in};
  endfunction

  always @(posedge clk) re_seen <= bus_re;

  always @(negedge clk) begin
    if (re_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10: unexpected read result actual %02h expected none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 stage_en", {7'b0, stage_en}, 8'h00);
    check("R1 slew_sel", {6'b0, slew_sel}, 8'h00);
    check("R1 ilim_sel", {5'b0, ilim_sel}, 8'h00);
    check("R1 sup_out_en", {7'b0, sup_out_en}, 8'h00);
    rd(8'h03, 8'h00, "R1 ctrl");
    rd(8'h01, 8'h00, "R1 pwr");
    rd(8'h0C, 8'h00, "R1 stat");

    wr(8'h03, 8'hFF);
    check("R2 stage_en", {7'b0, stage_en}, 8'h01);
    check("R2 slew 4x", {6'b0, slew_sel}, 8'h03);
    rd(8'h03, 8'hE0, "R2 ctrl readback");
    wr(8'h03, 8'h40);
    check("R2 slew 8x", {6'b0, slew_sel}, 8'h02);
    check("R2 stage off", {7'b0, stage_en}, 8'h00);
    wr(8'h03, 8'h20);
    check("R2 slew 10k", {6'b0, slew_sel}, 8'h01);

    wr(8'h01, 8'hFF);
    check("R3 ilim", {5'b0, ilim_sel}, 8'h07);
    rd(8'h01, 8'h87, "R3 pwr readback");
    check("R4 off without stage", {7'b0, sup_out_en}, 8'h00);
    wr(8'h01, 8'h03);
    check("R3 ilim 011", {5'b0, ilim_sel}, 8'h03);
    check("R4 off without on bit", {7'b0, sup_out_en}, 8'h00);
    wr(8'h01, 8'h84);
    wr(8'h03, 8'h80);
    check("R4 on", {7'b0, sup_out_en}, 8'h01);

    lv_flag_in = 1; hv_flag_in = 1; lin_ilim_in = 1; hb_oc_in = 1;
    #1 check("R9 lv/hv no effect", {7'b0, sup_out_en}, 8'h01);
    rd(8'h0C, stat(1'b0), "R9 status copies");
    wr(8'h0C, 8'hDF);
    rd(8'h0C, stat(1'b0), "R9 writes ignored");
    lv_flag_in = 0; hv_flag_in = 0; lin_ilim_in = 0; hb_oc_in = 0;

    sup_oc_in = 1;
    #1 check("R5 off same cycle", {7'b0, sup_out_en}, 8'h00);
    @(negedge clk);
    sup_oc_in = 0;
    #1 check("R5 stays off", {7'b0, sup_out_en}, 8'h00);
    rd(8'h0C, 8'h20, "R5 flag latched");
    wr(8'h0C, 8'h00);
    rd(8'h0C, 8'h20, "R6 write 0 no effect");
    check("R6 still off", {7'b0, sup_out_en}, 8'h00);
    wr(8'h0C, 8'h20);
    check("R6 output back", {7'b0, sup_out_en}, 8'h01);
    rd(8'h0C, 8'h00, "R6 flag cleared");

    sup_oc_in = 1; bus_we = 1; bus_addr = 8'h0C; bus_wdata = 8'h20;
    @(negedge clk);
    sup_oc_in = 0; bus_we = 0;
    #1 check("R7 set wins output", {7'b0, sup_out_en}, 8'h00);
    rd(8'h0C, 8'h20, "R7 set wins flag");
    wr(8'h0C, 8'h20);

    ht_flag_in = 1;
    #1 check("R8 ht alone no effect", {7'b0, sup_out_en}, 8'h01);
    ht_rst_en_in = 1;
    #1 check("R8 shutdown", {7'b0, sup_out_en}, 8'h00);
    rd(8'h0C, 8'h01, "R9 ht copy");
    ht_flag_in = 0;
    #1 check("R8 recovers", {7'b0, sup_out_en}, 8'h01);

    rd(8'h05, 8'h00, "R10 unmapped");
    rd(8'h03, 8'h80, "R10 ctrl");
    @(negedge clk);
    check("R10 idle zero", bus_rdata, 8'h00);
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule